// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block collects interrupt requests from the on-chip sources of a small microcontroller (one timer, two DMA channels and a parameterised set of external inputs) and presents a single interrupt request to the CPU. Each source has a control register that holds a 3-bit priority and a mask bit. A global priority threshold gates every maskable source. A mask register gives a second view of all the per-source mask bits. An in-service register records which sources the CPU is handling.

Each source latches a pending bit on a rising edge of its request line. The controller picks the most urgent pending source that is unmasked, passes the threshold and outranks everything in service. It raises `cpu_irq` for that source. When the CPU acknowledges, the controller reports the source identifier, marks the source in service, and blocks equal or less urgent requests until software writes an end-of-interrupt command. That command either names a source or, in its non-specific form, retires the most urgent source in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the threshold reads 7. Every source is masked: the mask register reads 0x003D with the default two external inputs. Every control register reads 0x000F (mask bit 3 set, priority 7). The in-service register reads 0 and `cpu_irq` is low.
- R2: The threshold register (address 0) stores bits 2:0 only. Bits 15:3 always read 0.
- R3: A source whose priority number is greater than the threshold cannot raise `cpu_irq`. A priority number equal to the threshold passes.
- R4: Bit i of the mask register (address 1) and bit 3 of control register i (address 4+i) are one storage bit. A write through either view reads back through the other.
- R5: A rising edge on a request line sets that source's pending bit. The bit stays set while the source is masked, and the request is raised once the source is unmasked.
- R6: Among eligible sources, the lowest priority number (0 = most urgent) wins. Ties go to the timer, then DMA0, then DMA1, then the external inputs in index order.
- R7: On `cpu_ack` with a winner present, the winner's pending bit clears and its in-service bit sets. `ack_vld` is high for exactly the next cycle, with `ack_id` holding the winner's slot.
- R8: While any source is in service, a request is eligible only if its priority number is strictly below the lowest priority number in service.
- R9: Writing to address 3 with bit 15 clear clears the in-service bit whose slot number is in the low bits of the data.
- R10: Writing to address 3 with bit 15 set clears only the in-service bit of the most urgent source in service, using the ordering of R6.
- R11: `cpu_irq` is combinational from registered state. It drops in the cycle after an acknowledge when no other source is eligible.
- R12: Slot numbers, which are also the bit positions of the in-service register (address 2) and the mask register, are: timer 0, DMA0 2, DMA1 3, external input k at 4+k. Bit 1 is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_req | input | 1 | Timer request line |
| dma_req | input | 2 | DMA channel request lines |
| ext_req | input | NUM_EXT | External request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU |
| ack_vld | output | 1 | Identifier valid, one cycle after acknowledge |
| ack_id | output | IDX_W | Slot number of the acknowledged source |

## Verification
The arbiter is tried with three input patterns. A single request checks the plain path. Simultaneous requests at different priorities show whether the priority number decides the winner. Simultaneous requests at equal priority show whether the fixed slot order breaks the tie. Nested patterns check the strict in-service comparison: a request equal to the one in service must stay blocked, while a more urgent one gets through. Non-specific end-of-interrupt is then run against two in-service bits, which shows whether only the most urgent one is retired. Threshold steps on either side of a pending priority, and mask writes through each view while a request is pending, test the gating and the aliasing.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_LEAST = prio_t'(7);

    // slot numbers double as in-service / mask bit positions
    localparam int SLOT_TMR  = 0;
    localparam int SLOT_RSVD = 1;
    localparam int SLOT_DMA0 = 2;
    localparam int SLOT_DMA1 = 3;
    localparam int SLOT_EXT0 = 4;

    // register map
    localparam int ADR_THRESH = 0;
    localparam int ADR_MASK   = 1;
    localparam int ADR_INSERV = 2;
    localparam int ADR_EOI    = 3;
    localparam int ADR_CTRL0  = 4;

    localparam int EOI_NONSPEC_BIT = 15;
    localparam int CTRL_MSK_BIT    = 3;

    typedef struct packed {
        logic  msk;
        prio_t prio;
    } src_ctrl_t;

    function automatic int num_slots(input int n_ext);
        return SLOT_EXT0 + n_ext;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_prio_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] req,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSLOT-1:0] pend
);
    logic [NSLOT-1:0] req_q;
    logic [NSLOT-1:0] rise;
    logic [NSLOT-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int i = 0; i < NSLOT; i++) begin
            clr_vec[i] = clr_en && (clr_idx == IDX_W'(i));
        end
        rise = req & ~req_q;
        rise[SLOT_RSVD] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr_vec) | rise;
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_prio_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int IDX_W = 3
) (
    input  logic [NSLOT-1:0]             cand,
    input  logic [NSLOT-1:0][PRIO_W-1:0] prio_vec,
    output logic                         found,
    output logic [IDX_W-1:0]             idx,
    output prio_t                        best
);
    // scan from the top so that on equal priority the lower slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = PRIO_LEAST;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio_vec[i] <= best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio_vec[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_prio_pkg::*;
#(
    parameter  int NUM_EXT = 2,
    parameter  int DATA_W  = 16,
    parameter  int ADDR_W  = 4,
    localparam int NSLOT   = SLOT_EXT0 + NUM_EXT,
    localparam int IDX_W   = $clog2(NSLOT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tmr_req,
    input  logic [1:0]         dma_req,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               cpu_irq,
    input  logic               cpu_ack,
    output logic               ack_vld,
    output logic [IDX_W-1:0]   ack_id
);
    localparam logic [NSLOT-1:0] USED = ~(NSLOT'(1) << SLOT_RSVD);

    logic [NSLOT-1:0]             req_vec;
    logic [NSLOT-1:0]             pend;
    logic [NSLOT-1:0]             msk;
    logic [NSLOT-1:0][PRIO_W-1:0] prio;
    logic [NSLOT-1:0]             isr;
    prio_t                        thresh;

    logic [NSLOT-1:0] cand;
    logic             win_any, isr_any, take;
    logic [IDX_W-1:0] win_idx, isr_idx, eoi_idx;
    prio_t            win_prio, isr_min;
    logic             wr_thresh, wr_mask, wr_eoi, wr_ctrl, ctrl_hit, eoi_hit;
    logic [IDX_W-1:0] ctrl_slot;
    logic [NSLOT-1:0] isr_clr, isr_set;
    src_ctrl_t        ctrl_rd;

    assign req_vec = {ext_req, dma_req[1], dma_req[0], 1'b0, tmr_req};

    // register decode
    assign wr_thresh = reg_wr && (int'(reg_addr) == ADR_THRESH);
    assign wr_mask   = reg_wr && (int'(reg_addr) == ADR_MASK);
    assign wr_eoi    = reg_wr && (int'(reg_addr) == ADR_EOI);
    assign ctrl_hit  = (int'(reg_addr) >= ADR_CTRL0) && (int'(reg_addr) < ADR_CTRL0 + NSLOT);
    assign ctrl_slot = IDX_W'(int'(reg_addr) - ADR_CTRL0);
    assign wr_ctrl   = reg_wr && ctrl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh <= PRIO_LEAST;
        end else if (wr_thresh) begin
            thresh <= reg_wdata[PRIO_W-1:0];
        end
    end

    // per-source control: one mask bit, seen through two addresses
    always_ff @(posedge clk) begin
        if (rst) begin
            msk  <= USED;
            prio <= '1;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (wr_mask) begin
                    msk[i] <= reg_wdata[i] & USED[i];
                end else if (wr_ctrl && ctrl_slot == IDX_W'(i) && USED[i]) begin
                    msk[i]  <= reg_wdata[CTRL_MSK_BIT];
                    prio[i] <= reg_wdata[PRIO_W-1:0];
                end
            end
        end
    end

    irq_pend_bank #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (req_vec),
        .clr_en  (take),
        .clr_idx (win_idx),
        .pend    (pend)
    );

    // most urgent source currently in service
    irq_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_isr_pick (
        .cand     (isr),
        .prio_vec (prio),
        .found    (isr_any),
        .idx      (isr_idx),
        .best     (isr_min)
    );

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            cand[i] = pend[i] && !msk[i] && (prio[i] <= thresh)
                      && (!isr_any || prio[i] < isr_min);
        end
    end

    irq_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_req_pick (
        .cand     (cand),
        .prio_vec (prio),
        .found    (win_any),
        .idx      (win_idx),
        .best     (win_prio)
    );

    assign cpu_irq = win_any;
    assign take    = cpu_ack && win_any;

    // in-service tracking
    assign eoi_idx = reg_wdata[EOI_NONSPEC_BIT] ? isr_idx : reg_wdata[IDX_W-1:0];
    assign eoi_hit = wr_eoi && (!reg_wdata[EOI_NONSPEC_BIT] || isr_any);

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            isr_clr[i] = eoi_hit && (eoi_idx == IDX_W'(i));
            isr_set[i] = take && (win_idx == IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            ack_vld <= 1'b0;
            ack_id  <= '0;
        end else begin
            isr     <= ((isr & ~isr_clr) | isr_set) & USED;
            ack_vld <= take;
            ack_id  <= win_idx;
        end
    end

    // read mux
    always_comb begin
        ctrl_rd   = '{msk: msk[ctrl_slot], prio: prio[ctrl_slot]};
        reg_rdata = '0;
        if (int'(reg_addr) == ADR_THRESH) begin
            reg_rdata = DATA_W'(thresh);
        end else if (int'(reg_addr) == ADR_MASK) begin
            reg_rdata = DATA_W'(msk);
        end else if (int'(reg_addr) == ADR_INSERV) begin
            reg_rdata = DATA_W'(isr);
        end else if (ctrl_hit && int'(ctrl_slot) != SLOT_RSVD) begin
            reg_rdata = DATA_W'(ctrl_rd);
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int NSLOT  = 6,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ack,
    input logic              cpu_irq,
    input logic              ack_vld,
    input logic [IDX_W-1:0]  ack_id,
    input logic [NSLOT-1:0]  isr,
    input logic [NSLOT-1:0]  pend,
    input prio_t             win_prio,
    input logic              isr_any,
    input prio_t             isr_min,
    input prio_t             thresh,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(cpu_ack));                                   // R7
    AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> isr[ack_id]);                                      // R7
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack |=> (($past(pend) & ~pend) == '0));                    // R5
    AST_THRESH_GATE: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (win_prio <= thresh));                             // R3
    AST_NEST_STRICT: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && isr_any) |-> (win_prio < isr_min));                // R8
    AST_RSVD_ISR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !isr[SLOT_RSVD]);                                              // R12
    AST_RSVD_NEVER_ACKED: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> (ack_id != IDX_W'(SLOT_RSVD)));                    // R12
    AST_THRESH_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_addr) == ADR_THRESH) |-> (reg_rdata[DATA_W-1:PRIO_W] == '0)); // R2
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
    .NSLOT(NSLOT), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ack   (cpu_ack),
    .cpu_irq   (cpu_irq),
    .ack_vld   (ack_vld),
    .ack_id    (ack_id),
    .isr       (isr),
    .pend      (pend),
    .win_prio  (win_prio),
    .isr_any   (isr_any),
    .isr_min   (isr_min),
    .thresh    (thresh),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int NUM_EXT = 2;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int IDX_W   = 3;

    // slot / address numbers as stated in R12 and R4
    localparam int A_THR = 0, A_MSK = 1, A_ISR = 2, A_EOI = 3;
    localparam int A_TMR = 4, A_DMA0 = 6, A_DMA1 = 7, A_EXT0 = 8, A_EXT1 = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tmr_req = 1'b0;
    logic [1:0] dma_req = '0;
    logic [NUM_EXT-1:0] ext_req = '0;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic cpu_irq;
    logic cpu_ack = 1'b0;
    logic ack_vld;
    logic [IDX_W-1:0] ack_id;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_EXT(NUM_EXT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk, .rst, .tmr_req, .dma_req, .ext_req, .reg_wr, .reg_addr,
        .reg_wdata, .reg_rdata, .cpu_irq, .cpu_ack, .ack_vld, .ack_id
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = ADDR_W'(a);
        #0.5;
        d = int'(reg_rdata);
    endtask

    task automatic pulse(input logic t, input logic [1:0] d, input logic [NUM_EXT-1:0] e);
        @(negedge clk);
        tmr_req = t; dma_req = d; ext_req = e;
        @(negedge clk);
        tmr_req = 1'b0; dma_req = '0; ext_req = '0;
    endtask

    task automatic ack(input string req, input int exp_id);
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk(req, int'(ack_vld), 1);
        chk(req, int'(ack_id), exp_id);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(A_THR, v);  chk("R1 thresh", v, 7);
        rd(A_MSK, v);  chk("R1 mask", v, 'h3D);
        rd(A_ISR, v);  chk("R1 inserv", v, 0);
        rd(A_EXT1, v); chk("R1 ctrl", v, 'hF);
        chk("R1 irq", int'(cpu_irq), 0);
    endtask

    task automatic t_thresh_field();
        int v;
        do_reset();
        wr(A_THR, 'hFFFA);
        rd(A_THR, v); chk("R2 reserved bits", v, 2);
    endtask

    task automatic t_single();
        int v;
        do_reset();
        wr(A_TMR, 'h3);
        pulse(1'b1, 2'b00, '0);
        chk("R5 irq after edge", int'(cpu_irq), 1);
        ack("R7 ack timer", 0);
        chk("R11 irq dropped", int'(cpu_irq), 0);
        rd(A_ISR, v); chk("R12 timer bit0", v, 'h1);
        @(negedge clk);
        chk("R7 ack one cycle", int'(ack_vld), 0);
        wr(A_EOI, 0);
        rd(A_ISR, v); chk("R9 specific eoi", v, 0);
        chk("R7 pending cleared", int'(cpu_irq), 0);
    endtask

    task automatic t_prio();
        int v;
        do_reset();
        wr(A_DMA0, 'h5);
        wr(A_EXT0, 'h2);
        pulse(1'b0, 2'b01, 2'b01);
        ack("R6 lowest number wins", 4);
        rd(A_ISR, v); chk("R12 ext0 bit4", v, 'h10);
        chk("R8 less urgent blocked", int'(cpu_irq), 0);
        wr(A_EOI, 4);
        chk("R9 eoi releases", int'(cpu_irq), 1);
        ack("R6 next winner dma0", 2);
    endtask

    task automatic t_tie();
        do_reset();
        wr(A_DMA0, 'h4);
        wr(A_DMA1, 'h4);
        wr(A_EXT1, 'h4);
        pulse(1'b0, 2'b11, 2'b10);
        ack("R6 tie dma0 first", 2);
        wr(A_EOI, 'h8000);
        ack("R6 tie dma1 second", 3);
        wr(A_EOI, 'h8000);
        ack("R6 tie ext1 last", 5);
    endtask

    task automatic t_thresh();
        do_reset();
        wr(A_THR, 3);
        wr(A_EXT1, 'h4);
        pulse(1'b0, 2'b00, 2'b10);
        chk("R3 above threshold blocked", int'(cpu_irq), 0);
        wr(A_THR, 4);
        chk("R3 equal threshold passes", int'(cpu_irq), 1);
    endtask

    task automatic t_mask();
        int v;
        do_reset();
        wr(A_DMA1, 'h9);
        pulse(1'b0, 2'b10, '0);
        chk("R5 masked pending silent", int'(cpu_irq), 0);
        wr(A_MSK, 'h35);
        rd(A_DMA1, v); chk("R4 mask reg to ctrl", v, 'h1);
        chk("R5 held pending raised", int'(cpu_irq), 1);
        wr(A_DMA1, 'h9);
        rd(A_MSK, v); chk("R4 ctrl to mask reg", v, 'h3D);
        chk("R4 remasked", int'(cpu_irq), 0);
    endtask

    task automatic t_nest();
        int v;
        do_reset();
        wr(A_TMR, 'h3);
        wr(A_EXT0, 'h3);
        wr(A_DMA0, 'h2);
        pulse(1'b1, 2'b00, '0);
        ack("R7 ack timer", 0);
        pulse(1'b0, 2'b00, 2'b01);
        chk("R8 equal blocked", int'(cpu_irq), 0);
        pulse(1'b0, 2'b01, '0);
        chk("R8 more urgent passes", int'(cpu_irq), 1);
        ack("R8 nested ack dma0", 2);
        rd(A_ISR, v); chk("R12 two bits", v, 'h5);
        wr(A_EOI, 'h8000);
        rd(A_ISR, v); chk("R10 most urgent cleared", v, 'h1);
        chk("R10 ext0 still blocked", int'(cpu_irq), 0);
        wr(A_EOI, 'h8000);
        rd(A_ISR, v); chk("R10 second clear", v, 0);
        chk("R10 ext0 released", int'(cpu_irq), 1);
        ack("R10 ack ext0", 4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_thresh_field();
        t_single();
        t_prio();
        t_tie();
        t_thresh();
        t_mask();
        t_nest();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule